// File: doc/BRIEF.md
# Bitslip Word Aligner with Training Sequencer

This block finds the word boundary of a 32-bit receive lane by requesting single-bit slips from the transceiver until a fixed training word arrives with the matching control marker. While it is hunting, each valid word that does not match causes one slip request. After each request the block waits a fixed settle time before it compares again. When the training word is found, the block declares the lane aligned and makes no more slip requests.

Once aligned, the block expects an incrementing counter payload tagged with the payload control code. It reports two kinds of fault. A control fault is a word with the wrong tag. A counter fault is a payload word that is not one more than the previous one. Either fault drops alignment and sends the receiver back to hunting.

A small transmit sequencer in the same block produces the matching stream. It sends the training word for a fixed number of cycles after reset and then a free-running counter. The serializer, the clock recovery and the elastic buffers are outside this block.

Top module: `slip_align_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `txData` is 0x12345678, `txCtl` is 2'b10, and `rxBitslip`, `rxAligned`, `rxCtlErr` and `rxCntErr` are all low.
- R2: After reset the transmitter shows the training word 0x12345678 with control 2'b10 for TRAIN_BEATS cycles (the cycle released from reset is included). It then sends 0, 1, 2, … with control 2'b01. The counter goes up by one each cycle and wraps modulo 2^32.
- R3: While hunting, a valid received word that is not both data 0x12345678 and control 2'b10 raises `rxBitslip` for exactly one cycle, starting in the next cycle.
- R4: After a slip request the receiver compares no word for SETTLE_CYC (8) cycles. If every compared word mismatches, consecutive requests are exactly SETTLE_CYC+1 cycles apart. A training word received inside the settle window does not cause alignment.
- R5: While hunting, a valid word with data 0x12345678 and control 2'b10 sets `rxAligned` high from the next cycle, and no slip request is made for that word.
- R6: `rxBitslip` is low in every cycle in which `rxAligned` is high.
- R7: A cycle with `rxValid` low is ignored. It causes no slip, no comparison, no fault and no change of alignment.
- R8: After alignment, exact training words (data 0x12345678, control 2'b10) are accepted without a fault until the first payload word arrives. The first payload word (control 2'b01) sets the counter reference and is not checked.
- R9: Each later valid payload word must equal the previous payload word plus one, modulo 2^32. Otherwise `rxCntErr` pulses for one cycle, `rxAligned` falls in that same cycle, and the receiver goes back to hunting.
- R10: An aligned valid word whose control is not 2'b01, and which R8 does not accept, pulses `rxCtlErr` for one cycle and drops alignment. `rxCntErr` stays low for that word.
- R11: Asserting `rst` during operation returns the transmitter to the training word and the receiver to hunting on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txData | output | DATA_W | Transmit parallel word |
| txCtl | output | CTL_W | Transmit control tag |
| rxValid | input | 1 | Received word is valid this cycle |
| rxData | input | DATA_W | Received parallel word |
| rxCtl | input | CTL_W | Received control tag |
| rxBitslip | output | 1 | One-cycle request to shift the boundary by one bit |
| rxAligned | output | 1 | Boundary found and payload being checked |
| rxCtlErr | output | 1 | One-cycle pulse on a control tag fault |
| rxCntErr | output | 1 | One-cycle pulse on a counter break |

## Verification
Some rules hold in every cycle, and the assertions check these continuously:
- a slip request lasts exactly one cycle;
- two slip requests are never closer than the settle gap;
- no slip request is made while aligned;
- alignment rises only after a training word was seen;
- a fault comes from an aligned valid word and drops alignment;
- the two fault kinds never coincide;
- the transmitted counter always steps by one.

Other behaviour needs whole scenarios, and only the bench can show it:
- the exact number of slips, and the exact cycle of lock, from a known bit offset of a looped-back stream;
- a training word ignored when it arrives inside the settle window;
- counter wrap;
- training words tolerated before the first payload word and refused after it.

// File: rtl/slip_align_pkg.sv
package slip_align_pkg;

  typedef enum logic [1:0] {
    RX_HUNT   = 2'd0,
    RX_SETTLE = 2'd1,
    RX_LOCKED = 2'd2
  } rxStateT;

  // strobes from the receive control to the receive datapath
  typedef struct packed {
    logic slipPulse;
    logic startSettle;
    logic loadRef;
    logic clearRef;
    logic raiseCtlErr;
    logic raiseCntErr;
  } rxStrobeT;

  // compare results from the datapath back to the control
  typedef struct packed {
    logic trainHit;
    logic payloadCtl;
    logic seqOk;
    logic haveRef;
    logic settleDone;
  } rxStatusT;

endpackage

// File: rtl/slip_align_txseq.sv
module slip_align_txseq #(
  parameter int DATA_W = 32,
  parameter int CTL_W = 2,
  parameter logic [DATA_W-1:0] TRAIN_WORD = 32'h1234_5678,
  parameter logic [CTL_W-1:0] TRAIN_CTL = 2'b10,
  parameter logic [CTL_W-1:0] DATA_CTL = 2'b01,
  parameter int TRAIN_BEATS = 64
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] txData,
  output logic [CTL_W-1:0]  txCtl
);

  localparam int BEAT_W = $clog2(TRAIN_BEATS + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(TRAIN_BEATS - 1);

  logic              inPayload;
  logic [BEAT_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      inPayload <= 1'b0;
      beatCnt   <= '0;
      txData    <= TRAIN_WORD;
      txCtl     <= TRAIN_CTL;
    end else if (!inPayload) begin
      if (beatCnt == LAST_BEAT) begin
        inPayload <= 1'b1;
        txData    <= '0;
        txCtl     <= DATA_CTL;
      end else begin
        beatCnt <= beatCnt + BEAT_W'(1);
      end
    end else begin
      txData <= txData + DATA_W'(1);
    end
  end

endmodule

// File: rtl/slip_align_rxdp.sv
module slip_align_rxdp
  import slip_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTL_W = 2,
  parameter logic [DATA_W-1:0] TRAIN_WORD = 32'h1234_5678,
  parameter logic [CTL_W-1:0] TRAIN_CTL = 2'b10,
  parameter logic [CTL_W-1:0] DATA_CTL = 2'b01,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rxData,
  input  logic [CTL_W-1:0]  rxCtl,
  input  rxStrobeT          strobe,
  output rxStatusT          status,
  output logic              rxBitslip,
  output logic              rxCtlErr,
  output logic              rxCntErr
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

  logic [DATA_W-1:0] refWord;
  logic              haveRef;
  logic [CNT_W-1:0]  settleCnt;

  always_comb begin
    status.trainHit   = (rxData == TRAIN_WORD) && (rxCtl == TRAIN_CTL);
    status.payloadCtl = (rxCtl == DATA_CTL);
    status.seqOk      = (rxData == refWord + DATA_W'(1));
    status.haveRef    = haveRef;
    status.settleDone = (settleCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refWord   <= '0;
      haveRef   <= 1'b0;
      settleCnt <= '0;
      rxBitslip <= 1'b0;
      rxCtlErr  <= 1'b0;
      rxCntErr  <= 1'b0;
    end else begin
      rxBitslip <= strobe.slipPulse;
      rxCtlErr  <= strobe.raiseCtlErr;
      rxCntErr  <= strobe.raiseCntErr;
      if (strobe.startSettle) begin
        settleCnt <= SETTLE_LOAD;
      end else if (settleCnt != '0) begin
        settleCnt <= settleCnt - CNT_W'(1);
      end
      if (strobe.clearRef) begin
        haveRef <= 1'b0;
      end else if (strobe.loadRef) begin
        refWord <= rxData;
        haveRef <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/slip_align_rxctl.sv
module slip_align_rxctl
  import slip_align_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rxValid,
  input  rxStatusT status,
  output rxStrobeT strobe,
  output logic     rxAligned
);

  rxStateT state;
  rxStateT nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      RX_HUNT: begin
        if (rxValid) begin
          if (status.trainHit) begin
            nextState       = RX_LOCKED;
            strobe.clearRef = 1'b1;
          end else begin
            nextState          = RX_SETTLE;
            strobe.slipPulse   = 1'b1;
            strobe.startSettle = 1'b1;
          end
        end
      end
      RX_SETTLE: begin
        if (status.settleDone) nextState = RX_HUNT;
      end
      RX_LOCKED: begin
        if (rxValid) begin
          if (status.payloadCtl) begin
            if (!status.haveRef || status.seqOk) begin
              strobe.loadRef = 1'b1;
            end else begin
              strobe.raiseCntErr = 1'b1;
              nextState          = RX_HUNT;
            end
          end else if (!(status.trainHit && !status.haveRef)) begin
            strobe.raiseCtlErr = 1'b1;
            nextState          = RX_HUNT;
          end
        end
      end
      default: nextState = RX_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= RX_HUNT;
    else     state <= nextState;
  end

  assign rxAligned = (state == RX_LOCKED);

endmodule

// File: rtl/slip_align_top.sv
module slip_align_top
  import slip_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTL_W = 2,
  parameter logic [DATA_W-1:0] TRAIN_WORD = 32'h1234_5678,
  parameter logic [CTL_W-1:0] TRAIN_CTL = 2'b10,
  parameter logic [CTL_W-1:0] DATA_CTL = 2'b01,
  parameter int SETTLE_CYC = 8,
  parameter int TRAIN_BEATS = 64
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] txData,
  output logic [CTL_W-1:0]  txCtl,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [CTL_W-1:0]  rxCtl,
  output logic              rxBitslip,
  output logic              rxAligned,
  output logic              rxCtlErr,
  output logic              rxCntErr
);

  rxStrobeT strobe;
  rxStatusT status;

  slip_align_txseq #(
    .DATA_W(DATA_W), .CTL_W(CTL_W), .TRAIN_WORD(TRAIN_WORD),
    .TRAIN_CTL(TRAIN_CTL), .DATA_CTL(DATA_CTL), .TRAIN_BEATS(TRAIN_BEATS)
  ) u_tx (
    .clk(clk), .rst(rst), .txData(txData), .txCtl(txCtl)
  );

  slip_align_rxdp #(
    .DATA_W(DATA_W), .CTL_W(CTL_W), .TRAIN_WORD(TRAIN_WORD),
    .TRAIN_CTL(TRAIN_CTL), .DATA_CTL(DATA_CTL), .SETTLE_CYC(SETTLE_CYC)
  ) u_dp (
    .clk(clk), .rst(rst), .rxData(rxData), .rxCtl(rxCtl),
    .strobe(strobe), .status(status),
    .rxBitslip(rxBitslip), .rxCtlErr(rxCtlErr), .rxCntErr(rxCntErr)
  );

  slip_align_rxctl u_ctl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .status(status),
    .strobe(strobe), .rxAligned(rxAligned)
  );

endmodule

// File: rtl/slip_align_chk.sv
module slip_align_chk #(
  parameter int DATA_W = 32,
  parameter int CTL_W = 2,
  parameter logic [DATA_W-1:0] TRAIN_WORD = 32'h1234_5678,
  parameter logic [CTL_W-1:0] TRAIN_CTL = 2'b10,
  parameter logic [CTL_W-1:0] DATA_CTL = 2'b01,
  parameter int SETTLE_CYC = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] txData,
  input logic [CTL_W-1:0]  txCtl,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic [CTL_W-1:0]  rxCtl,
  input logic              rxBitslip,
  input logic              rxAligned,
  input logic              rxCtlErr,
  input logic              rxCntErr
);

  localparam int GAP_W = $clog2(SETTLE_CYC + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(SETTLE_CYC + 1);

  // cycles since the last slip request, saturating at the minimum gap
  logic [GAP_W-1:0] sinceSlip;

  always_ff @(posedge clk) begin
    if (rst)                    sinceSlip <= GAP_MIN;
    else if (rxBitslip)         sinceSlip <= GAP_W'(1);
    else if (sinceSlip < GAP_MIN) sinceSlip <= sinceSlip + GAP_W'(1);
  end

  assert_slip_single_R3: assert property (@(posedge clk) disable iff (rst)
    rxBitslip |=> !rxBitslip);

  assert_slip_from_valid_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rxBitslip) |-> $past(rxValid));

  assert_settle_gap_R4: assert property (@(posedge clk) disable iff (rst)
    rxBitslip |-> (sinceSlip >= GAP_MIN));

  assert_quiet_locked_R6: assert property (@(posedge clk) disable iff (rst)
    rxAligned |-> !rxBitslip);

  assert_lock_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rxAligned) |-> ($past(rxValid) && $past(rxData) == TRAIN_WORD
                          && $past(rxCtl) == TRAIN_CTL));

  assert_err_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    rxCtlErr |-> !rxCntErr);

  assert_err_unlock_R9: assert property (@(posedge clk) disable iff (rst)
    (rxCtlErr || rxCntErr) |-> (!rxAligned && $past(rxAligned) && $past(rxValid)));

  assert_tx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (txCtl == DATA_CTL) |=> (txCtl == DATA_CTL && txData == $past(txData) + DATA_W'(1)));

  assert_tx_tag_R2: assert property (@(posedge clk) disable iff (rst)
    (txCtl == TRAIN_CTL) || (txCtl == DATA_CTL));

endmodule

bind slip_align_top slip_align_chk #(
  .DATA_W(DATA_W), .CTL_W(CTL_W), .TRAIN_WORD(TRAIN_WORD),
  .TRAIN_CTL(TRAIN_CTL), .DATA_CTL(DATA_CTL), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .txData(txData), .txCtl(txCtl),
  .rxValid(rxValid), .rxData(rxData), .rxCtl(rxCtl),
  .rxBitslip(rxBitslip), .rxAligned(rxAligned),
  .rxCtlErr(rxCtlErr), .rxCntErr(rxCntErr)
);

// File: tb/slip_align_top_tb.sv
module slip_align_top_tb;

  localparam int TB_BEATS = 512;
  localparam int SETTLE = 8;
  localparam logic [31:0] TRAIN = 32'h1234_5678;
  localparam logic [1:0] TCTL = 2'b10;
  localparam logic [1:0] PCTL = 2'b01;
  localparam int START_OFF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] txData;
  logic [1:0]  txCtl;
  logic rxValid;
  logic [31:0] rxData;
  logic [1:0]  rxCtl;
  logic rxBitslip, rxAligned, rxCtlErr, rxCntErr;

  logic useLoop = 1'b1;
  logic [4:0] slipOff = 5'(START_OFF);
  logic drvValid = 1'b0;
  logic [31:0] drvData = '0;
  logic [1:0] drvCtl = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] rotl(input logic [31:0] w, input logic [4:0] n);
    logic [63:0] d;
    d = {w, w} << n;
    return d[63:32];
  endfunction

  function automatic logic [31:0] expTxData(input int j);
    return (j < TB_BEATS) ? TRAIN : 32'(j - TB_BEATS);
  endfunction

  function automatic logic [1:0] expTxCtl(input int j);
    return (j < TB_BEATS) ? TCTL : PCTL;
  endfunction

  // loopback lane: the transmit stream seen through a bit offset
  assign rxValid = useLoop ? 1'b1 : drvValid;
  assign rxData  = useLoop ? rotl(txData, slipOff) : drvData;
  assign rxCtl   = useLoop ? txCtl : drvCtl;

  slip_align_top #(.SETTLE_CYC(SETTLE), .TRAIN_BEATS(TB_BEATS)) u_dut (
    .clk(clk), .rst(rst), .txData(txData), .txCtl(txCtl),
    .rxValid(rxValid), .rxData(rxData), .rxCtl(rxCtl),
    .rxBitslip(rxBitslip), .rxAligned(rxAligned),
    .rxCtlErr(rxCtlErr), .rxCntErr(rxCntErr)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] d, input logic [1:0] c);
    drvValid = v;
    drvData  = d;
    drvCtl   = c;
    @(negedge clk);
  endtask

  task automatic noFault(input string req);
    check(req, "rxCtlErr", rxCtlErr, 0);
    check(req, "rxCntErr", rxCntErr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cnt;
    int lockAt;
    int lastSlip;
    int slips;
    void'($urandom(32'd20240611));

    // ---------- reset state (R1)
    repeat (3) @(negedge clk);
    check("R1", "txData", txData, TRAIN);
    check("R1", "txCtl", txCtl, TCTL);
    check("R1", "rxBitslip", rxBitslip, 0);
    check("R1", "rxAligned", rxAligned, 0);
    noFault("R1");
    rst = 1'b0;

    // ---------- loopback: slip from offset 5 to 0, then payload (R2 R3 R4 R5 R6)
    lockAt = -1;
    lastSlip = -100;
    slips = 0;
    for (int j = 1; j <= 700; j++) begin
      @(negedge clk);
      if (j == 1) check("R1", "txData first cycle", txData, TRAIN);
      check("R2", "txData", txData, expTxData(j));
      check("R2", "txCtl", txCtl, expTxCtl(j));
      // pulses expected at 1, 10, ..., 235 (27 slips, gap SETTLE+1)
      check("R3", "rxBitslip", rxBitslip,
            ((j <= 1 + 26 * (SETTLE + 1)) && ((j - 1) % (SETTLE + 1) == 0)) ? 1 : 0);
      check("R5", "rxAligned", rxAligned, (j >= 2 + 26 * (SETTLE + 1) + SETTLE) ? 1 : 0);
      noFault("R8");
      if (rxAligned && lockAt < 0) lockAt = j;
      if (rxBitslip) begin
        if (slips > 0) check("R4", "slip gap", j - lastSlip, SETTLE + 1);
        lastSlip = j;
        slips++;
        slipOff = slipOff + 5'd1;
      end
    end
    check("R3", "slip count", slips, 32 - START_OFF);
    check("R5", "lock cycle", lockAt, 244);
    check("R6", "no slip after lock", rxBitslip, 0);

    // ---------- reset in operation (R11)
    rst = 1'b1;
    @(negedge clk);
    check("R11", "txData", txData, TRAIN);
    check("R11", "txCtl", txCtl, TCTL);
    check("R11", "rxAligned", rxAligned, 0);
    useLoop = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // ---------- invalid cycles ignored while hunting (R7)
    for (int i = 0; i < 5; i++) begin
      drive(1'b0, $urandom, 2'($urandom));
      check("R7", "rxBitslip idle", rxBitslip, 0);
      check("R7", "rxAligned idle", rxAligned, 0);
    end

    // ---------- direct lock (R5) and tolerated training words (R8)
    drive(1'b1, TRAIN, TCTL);
    check("R5", "rxAligned", rxAligned, 1);
    check("R5", "rxBitslip", rxBitslip, 0);
    drive(1'b1, TRAIN, TCTL);
    drive(1'b1, TRAIN, TCTL);
    check("R8", "training after lock", rxAligned, 1);
    noFault("R8");

    // ---------- random payload with random gaps (R7 R8 R9)
    cnt = $urandom;
    drive(1'b1, cnt, PCTL);
    check("R8", "first payload", rxAligned, 1);
    noFault("R8");
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        drive(1'b0, $urandom, 2'($urandom));
        check("R7", "gap keeps lock", rxAligned, 1);
        noFault("R7");
      end else begin
        cnt = cnt + 32'd1;
        drive(1'b1, cnt, PCTL);
        check("R9", "payload lock", rxAligned, 1);
        noFault("R9");
      end
    end

    // ---------- counter break (R9)
    drive(1'b1, cnt + 32'd2, PCTL);
    check("R9", "rxCntErr", rxCntErr, 1);
    check("R10", "rxCtlErr on break", rxCtlErr, 0);
    check("R9", "rxAligned drop", rxAligned, 0);
    drive(1'b0, $urandom, PCTL);
    check("R9", "rxCntErr single", rxCntErr, 0);

    // ---------- settle window ignores training word (R3 R4)
    drive(1'b1, $urandom | 32'h8000_0000, PCTL);
    check("R3", "slip on mismatch", rxBitslip, 1);
    for (int i = 0; i < SETTLE; i++) begin
      drive(1'b1, TRAIN, TCTL);
      check("R4", "no lock in settle", rxAligned, 0);
      check("R4", "no slip in settle", rxBitslip, 0);
    end
    drive(1'b1, TRAIN, TCTL);
    check("R4", "lock after settle", rxAligned, 1);

    // ---------- counter wrap (R9)
    drive(1'b1, 32'hFFFF_FFFE, PCTL);
    drive(1'b1, 32'hFFFF_FFFF, PCTL);
    drive(1'b1, 32'h0000_0000, PCTL);
    noFault("R9");
    drive(1'b1, 32'h0000_0001, PCTL);
    check("R9", "wrap lock", rxAligned, 1);
    noFault("R9");

    // ---------- bad control tag (R10)
    drive(1'b1, 32'h0000_0002, 2'b11);
    check("R10", "rxCtlErr", rxCtlErr, 1);
    check("R10", "rxCntErr", rxCntErr, 0);
    check("R10", "rxAligned drop", rxAligned, 0);

    // ---------- training word after payload is a control fault (R8 R10)
    drive(1'b1, TRAIN, TCTL);
    check("R5", "relock", rxAligned, 1);
    drive(1'b1, 32'd40, PCTL);
    drive(1'b1, 32'd41, PCTL);
    noFault("R8");
    drive(1'b1, TRAIN, TCTL);
    check("R10", "late training tag", rxCtlErr, 1);
    check("R10", "late training unlock", rxAligned, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule